// File: doc/BRIEF.md
# Power Management Watchdog Sequencer

This block is the digital core of a battery-powered baseband power manager. It waits in an off state until one of three wake events arrives: a press of the power button, a charger being plugged in, or a battery being attached. It then enables the regulators and holds an active-low system reset for a fixed power-on delay. After that delay it releases the reset. A watchdog counts from the first moment of power-up. If software does not acknowledge it in time, the block switches every regulator off again.

Software configures the block through a write-only three-wire serial port made of a chip select, a clock and a data line. Through this port it sets the watchdog length, acknowledges the watchdog, stores a reset threshold code, chooses which regulators stay on during sleep, closes the measurement switches and sets a charge PWM duty. While reset is held, several pins are taken over by this block: the sleep line, the charger-detect pin, the measurement switches and the charge PWM. When reset is released, these pins pass to their normal owners. Timing comes from a prescaled reference clock. The prescaler and the timeout scale are parameters, so that simulation can run with shortened time.

Top module: `pwr_wdog_seq`

## Requirements
- R1: A serial frame is 16 bits sent MSB first and sampled on the rising serial clock while chip select is low. The first 8 bits are the address and the last 8 bits are the data. If chip select goes high before the 16th bit, the frame is dropped. The register addresses are 0x01 watchdog length, 0x02 watchdog acknowledge (data ignored), 0x03 reset threshold code, 0x04 sleep options, 0x05 measurement switches and 0x06 PWM duty. Writes to any other address have no effect.
- R2: When the block is off, any one of these events powers it up: a falling edge on the button, a rising edge on charger-present, or a rising edge on battery-attach. On power-up all regulators turn on and reset is held low. While the block is off, all regulators are off and reset is low.
- R3: After power-up, reset stays low for PON_TICKS prescaler ticks and then goes high.
- R4: The watchdog counts ticks from power-up. Its count restarts when reset is released, when the acknowledge register is written, and when a nonzero length is written. When the count reaches length × WD_SCALE ticks, the block powers off. The default length is 32.
- R5: Writing 0 to the watchdog length register powers the block off within a few clock cycles of the last frame bit.
- R6: After a power-off, the block stays off as long as the input levels do not change. Only a new wake edge powers it up again. The watchdog length returns to its default value.
- R7: The charge PWM output is high while reset is low. It stays high after reset is released until the first write to the duty register. After that write, it is high in `duty` of every 256 clock cycles, so a duty of 0 keeps it low. After each power-up it is forced high again.
- R8: The sleep line is high while reset is low. After reset is released, the sleep line follows the sleep request input. While the block is off, the sleep line is low.
- R9: The charger-detect output enable is low while the block is off or in reset. After reset is released, the output enable is high and the charger-detect output drives the charger-present level.
- R10: The measurement switch outputs are open (low) while the block is off or in reset. After reset is released, they follow the measurement register: bit 0 controls the battery switch and bit 1 controls the charger switch.
- R11: The always-on regulator is enabled whenever the block is powered. The main and auxiliary regulators turn off while the sleep line is low, unless the corresponding keep bit is set in the sleep options register: bit 0 keeps the main regulator on and bit 1 keeps the auxiliary regulator on.
- R12: The reset threshold output shows register 0x03, which defaults to 0x33. Its value is kept across power-off and is cleared only by rst_ni.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the block itself |
| pwr_btn_ni | input | 1 | Power button, low when pressed |
| chg_present_i | input | 1 | Charger comparator result |
| bat_attach_i | input | 1 | Battery attached indication |
| sleep_req_ni | input | 1 | Sleep request from the system controller, low requests sleep |
| scs_ni | input | 1 | Serial chip select, active low |
| sclk_i | input | 1 | Serial clock |
| sdat_i | input | 1 | Serial data |
| reg_vsl_en_o | output | 1 | Always-on regulator enable |
| reg_main_en_o | output | 1 | Main logic regulator enable |
| reg_aux_en_o | output | 1 | Auxiliary regulator enable |
| sys_rst_no | output | 1 | System reset, active low |
| sleep_line_o | output | 1 | Sleep control line, high keeps clock source running |
| chg_det_o | output | 1 | Charger-detect pin drive value |
| chg_det_oe_o | output | 1 | Charger-detect pin output enable |
| meas_bat_o | output | 1 | Battery-to-ADC switch closed |
| meas_chg_o | output | 1 | Charger-to-ADC switch closed |
| chg_pwm_o | output | 1 | Charge PWM, high means charging |
| rst_level_o | output | 8 | Reset threshold code |

## Verification
Reset release and the internal watchdog acknowledge happen on the same clock edge. If the block gets this wrong, the first watchdog window is shortened by the power-on delay. The bench tests this by powering up with the default length and a long power-on delay. It checks that the block is still powered at a time after release at which a window counted from power-up would already have expired. It then checks that the block goes off shortly after the full window. On that same edge the sleep line and the charger-detect pin change owner, so the bench compares them with their new sources at the first sample where reset reads high.

// File: rtl/pws_pkg.sv
package pws_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] A_WD_LEN  = 8'h01;
  localparam logic [ADDR_W-1:0] A_WD_ACK  = 8'h02;
  localparam logic [ADDR_W-1:0] A_RST_LVL = 8'h03;
  localparam logic [ADDR_W-1:0] A_SLP_CFG = 8'h04;
  localparam logic [ADDR_W-1:0] A_MEAS    = 8'h05;
  localparam logic [ADDR_W-1:0] A_PWM     = 8'h06;

  typedef enum logic [1:0] {
    PS_OFF = 2'd0,
    PS_PON = 2'd1,
    PS_RUN = 2'd2
  } pstate_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } wr_t;
endpackage

// File: rtl/pws_serial_rx.sv
module pws_serial_rx import pws_pkg::*; (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic csn_i,
  input  logic sclk_i,
  input  logic sdat_i,
  output logic wr_vld_o,
  output wr_t  wr_o
);
  localparam int FRAME_W = ADDR_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W);

  logic [2:0] csn_q, sclk_q;
  logic [1:0] sdat_q;
  logic       csn_s, sdat_s, rise;
  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] sh_q;

  assign csn_s  = csn_q[1];
  assign sdat_s = sdat_q[1];
  assign rise   = sclk_q[1] & ~sclk_q[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csn_q  <= '1;
      sclk_q <= '0;
      sdat_q <= '0;
    end else begin
      csn_q  <= {csn_q[1:0], csn_i};
      sclk_q <= {sclk_q[1:0], sclk_i};
      sdat_q <= {sdat_q[0], sdat_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      sh_q     <= '0;
      wr_vld_o <= 1'b0;
      wr_o     <= '0;
    end else begin
      wr_vld_o <= 1'b0;
      if (csn_s) begin
        cnt_q <= '0;
      end else if (rise) begin
        sh_q <= {sh_q[FRAME_W-2:0], sdat_s};
        if (cnt_q == CNT_W'(FRAME_W-1)) begin
          cnt_q    <= '0;
          wr_vld_o <= 1'b1;
          wr_o     <= {sh_q[FRAME_W-2:0], sdat_s};
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R1: a frame strobe needs a fresh clock rise, so never two in a row
  a_r1_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_vld_o |=> !wr_vld_o);
endmodule

// File: rtl/pws_regfile.sv
module pws_regfile import pws_pkg::*; #(
  parameter int unsigned        WD_LEN_DEF  = 32,
  parameter logic [DATA_W-1:0]  RST_LVL_DEF = 8'h33
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_off_i,
  input  logic              wr_vld_i,
  input  wr_t               wr_i,
  output logic [DATA_W-1:0] wd_len_o,
  output logic              wd_restart_o,
  output logic              wd_kill_o,
  output logic [DATA_W-1:0] rst_lvl_o,
  output logic [1:0]        slp_cfg_o,
  output logic [1:0]        meas_o,
  output logic [DATA_W-1:0] pwm_duty_o,
  output logic              pwm_set_o
);
  logic wr_ok;
  assign wr_ok = wr_vld_i & ~pwr_off_i;

  assign wd_kill_o    = wr_ok && wr_i.addr == A_WD_LEN && wr_i.data == '0;
  assign wd_restart_o = wr_ok && (wr_i.addr == A_WD_ACK ||
                                  (wr_i.addr == A_WD_LEN && wr_i.data != '0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wd_len_o   <= DATA_W'(WD_LEN_DEF);
      rst_lvl_o  <= RST_LVL_DEF;
      slp_cfg_o  <= '0;
      meas_o     <= '0;
      pwm_duty_o <= '0;
      pwm_set_o  <= 1'b0;
    end else if (pwr_off_i) begin
      wd_len_o   <= DATA_W'(WD_LEN_DEF);
      slp_cfg_o  <= '0;
      meas_o     <= '0;
      pwm_duty_o <= '0;
      pwm_set_o  <= 1'b0;
    end else if (wr_vld_i) begin
      unique case (wr_i.addr)
        A_WD_LEN:  if (wr_i.data != '0) wd_len_o <= wr_i.data;
        A_RST_LVL: rst_lvl_o <= wr_i.data;
        A_SLP_CFG: slp_cfg_o <= wr_i.data[1:0];
        A_MEAS:    meas_o    <= wr_i.data[1:0];
        A_PWM: begin
          pwm_duty_o <= wr_i.data;
          pwm_set_o  <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  // R6: after any off cycle the length is back at its default
  a_r6_len_default: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_off_i |=> wd_len_o == DATA_W'(WD_LEN_DEF));
  // R7: first PWM write latches the set flag while powered
  a_r7_pwm_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ok && wr_i.addr == A_PWM |=> pwm_set_o);
endmodule

// File: rtl/pws_seq.sv
module pws_seq import pws_pkg::*; #(
  parameter int unsigned TICK_DIV  = 32,
  parameter int unsigned WD_SCALE  = 1000,
  parameter int unsigned PON_TICKS = 100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wake_i,
  input  logic [DATA_W-1:0] wd_len_i,
  input  logic              wd_restart_i,
  input  logic              wd_kill_i,
  output pstate_e           state_o
);
  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int PON_W = $clog2(PON_TICKS + 1);
  localparam int WD_W  = $clog2(256 * WD_SCALE + 1);
  localparam logic [WD_W-1:0] SCALE_V = WD_W'(WD_SCALE);

  logic [DIV_W-1:0] div_q;
  logic [PON_W-1:0] pon_q;
  logic [WD_W-1:0]  wd_q, wd_lim;
  logic tick, pon_done, expire, release_ev;
  pstate_e st_q, st_d;

  assign tick       = (div_q == DIV_W'(TICK_DIV - 1));
  assign pon_done   = tick && pon_q == PON_W'(PON_TICKS - 1);
  assign wd_lim     = {{(WD_W-DATA_W){1'b0}}, wd_len_i} * SCALE_V;
  assign expire     = st_q != PS_OFF && tick && (wd_q + WD_W'(1)) >= wd_lim;
  assign release_ev = st_q == PS_PON && pon_done;
  assign state_o    = st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= tick ? '0 : div_q + 1'b1;
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      PS_OFF: if (wake_i) st_d = PS_PON;
      PS_PON: begin
        if (wd_kill_i || expire) st_d = PS_OFF;
        else if (pon_done)       st_d = PS_RUN;
      end
      PS_RUN: if (wd_kill_i || expire) st_d = PS_OFF;
      default: st_d = PS_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= PS_OFF;
      pon_q <= '0;
      wd_q  <= '0;
    end else begin
      st_q <= st_d;
      if (st_q != PS_PON)  pon_q <= '0;
      else if (tick)       pon_q <= pon_q + 1'b1;
      // watchdog restarts itself on reset release
      if (st_q == PS_OFF || release_ev || wd_restart_i) wd_q <= '0;
      else if (tick)                                    wd_q <= wd_q + 1'b1;
    end
  end

  a_r2_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == PS_OFF && wake_i |=> st_q == PS_PON);
  a_r3_run_via_pon: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == PS_RUN |-> $past(st_q) != PS_OFF);
  a_r4_expire_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> st_q == PS_OFF);
  a_r5_kill_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_kill_i && st_q != PS_OFF |=> st_q == PS_OFF);
  a_r6_stay_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == PS_OFF && !wake_i |=> st_q == PS_OFF);
endmodule

// File: rtl/pws_pwm.sv
module pws_pwm #(
  parameter int PWM_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             force_i,
  input  logic [PWM_W-1:0] duty_i,
  output logic             pwm_o
);
  logic [PWM_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign pwm_o = force_i | (en_i & (cnt_q < duty_i));
endmodule

// File: rtl/pwr_wdog_seq.sv
module pwr_wdog_seq import pws_pkg::*; #(
  parameter int unsigned       TICK_DIV    = 32,
  parameter int unsigned       WD_SCALE    = 1000,
  parameter int unsigned       PON_TICKS   = 100,
  parameter int unsigned       WD_LEN_DEF  = 32,
  parameter logic [DATA_W-1:0] RST_LVL_DEF = 8'h33
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        pwr_btn_ni,
  input  logic        chg_present_i,
  input  logic        bat_attach_i,
  input  logic        sleep_req_ni,
  input  logic        scs_ni,
  input  logic        sclk_i,
  input  logic        sdat_i,
  output logic        reg_vsl_en_o,
  output logic        reg_main_en_o,
  output logic        reg_aux_en_o,
  output logic        sys_rst_no,
  output logic        sleep_line_o,
  output logic        chg_det_o,
  output logic        chg_det_oe_o,
  output logic        meas_bat_o,
  output logic        meas_chg_o,
  output logic        chg_pwm_o,
  output logic [7:0]  rst_level_o
);
  logic [2:0] btn_q, chg_q, bat_q;
  logic wake, powered, in_rst, running;
  logic wr_vld, wd_restart, wd_kill, pwm_set;
  wr_t  wr;
  logic [DATA_W-1:0] wd_len, pwm_duty;
  logic [1:0] slp_cfg, meas;
  pstate_e state;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      btn_q <= '1;
      chg_q <= '0;
      bat_q <= '0;
    end else begin
      btn_q <= {btn_q[1:0], pwr_btn_ni};
      chg_q <= {chg_q[1:0], chg_present_i};
      bat_q <= {bat_q[1:0], bat_attach_i};
    end
  end

  // wake on edges only: held levels cannot restart after a watchdog trip
  assign wake = (btn_q[2] & ~btn_q[1]) | (chg_q[1] & ~chg_q[2]) | (bat_q[1] & ~bat_q[2]);

  pws_serial_rx u_rx (
    .clk_i, .rst_ni,
    .csn_i(scs_ni), .sclk_i, .sdat_i,
    .wr_vld_o(wr_vld), .wr_o(wr)
  );

  pws_regfile #(.WD_LEN_DEF(WD_LEN_DEF), .RST_LVL_DEF(RST_LVL_DEF)) u_regs (
    .clk_i, .rst_ni,
    .pwr_off_i(state == PS_OFF),
    .wr_vld_i(wr_vld), .wr_i(wr),
    .wd_len_o(wd_len), .wd_restart_o(wd_restart), .wd_kill_o(wd_kill),
    .rst_lvl_o(rst_level_o), .slp_cfg_o(slp_cfg), .meas_o(meas),
    .pwm_duty_o(pwm_duty), .pwm_set_o(pwm_set)
  );

  pws_seq #(.TICK_DIV(TICK_DIV), .WD_SCALE(WD_SCALE), .PON_TICKS(PON_TICKS)) u_seq (
    .clk_i, .rst_ni,
    .wake_i(wake), .wd_len_i(wd_len),
    .wd_restart_i(wd_restart), .wd_kill_i(wd_kill),
    .state_o(state)
  );

  assign powered = state != PS_OFF;
  assign in_rst  = state == PS_PON;
  assign running = state == PS_RUN;

  pws_pwm #(.PWM_W(DATA_W)) u_pwm (
    .clk_i, .rst_ni,
    .en_i(running), .force_i(in_rst | (running & ~pwm_set)),
    .duty_i(pwm_duty), .pwm_o(chg_pwm_o)
  );

  assign sys_rst_no    = running;
  assign sleep_line_o  = in_rst | (running & sleep_req_ni);
  assign reg_vsl_en_o  = powered;
  assign reg_main_en_o = powered & (sleep_line_o | slp_cfg[0]);
  assign reg_aux_en_o  = powered & (sleep_line_o | slp_cfg[1]);
  assign chg_det_oe_o  = running;
  assign chg_det_o     = running & chg_q[1];
  assign meas_bat_o    = running & meas[0];
  assign meas_chg_o    = running & meas[1];

  a_r2_off_all_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_vsl_en_o |-> !sys_rst_no && !reg_main_en_o && !reg_aux_en_o);
  a_r7_pwm_forced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_vsl_en_o && !sys_rst_no |-> chg_pwm_o);
  a_r8_sleep_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_vsl_en_o && !sys_rst_no |-> sleep_line_o);
  a_r9_det_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sys_rst_no |-> !chg_det_oe_o && !chg_det_o);
  a_r10_meas_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sys_rst_no |-> !meas_bat_o && !meas_chg_o);
  a_r11_vsl_powered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_main_en_o || reg_aux_en_o) |-> reg_vsl_en_o);
endmodule

// File: tb/pwr_wdog_seq_tb_top.sv
module pwr_wdog_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 2;
  localparam int WD_SCALE   = 64;
  localparam int PON_TICKS  = 200;
  localparam int WD_DEF_CYC = 32 * WD_SCALE * TICK_DIV;
  localparam int PON_CYC    = PON_TICKS * TICK_DIV;

  // {sleep_req_n, slp_cfg[1:0], meas[1:0], exp main, aux, meas_bat, meas_chg}
  localparam logic [8:0] VEC [0:7] = '{
    9'b1_00_00_1100, 9'b0_00_01_0010, 9'b0_01_10_1001, 9'b0_10_11_0111,
    9'b0_11_00_1100, 9'b1_11_11_1111, 9'b1_00_10_1101, 9'b0_00_00_0000
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic pwr_btn_ni = 1'b1, chg_present_i = 1'b0, bat_attach_i = 1'b0, sleep_req_ni = 1'b1;
  logic scs_ni = 1'b1, sclk_i = 1'b0, sdat_i = 1'b0;
  logic reg_vsl_en_o, reg_main_en_o, reg_aux_en_o, sys_rst_no, sleep_line_o;
  logic chg_det_o, chg_det_oe_o, meas_bat_o, meas_chg_o, chg_pwm_o;
  logic [7:0] rst_level_o;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_wdog_seq #(.TICK_DIV(TICK_DIV), .WD_SCALE(WD_SCALE), .PON_TICKS(PON_TICKS)) dut_i (
    .clk_i(clk), .rst_ni, .pwr_btn_ni, .chg_present_i, .bat_attach_i, .sleep_req_ni,
    .scs_ni, .sclk_i, .sdat_i, .reg_vsl_en_o, .reg_main_en_o, .reg_aux_en_o,
    .sys_rst_no, .sleep_line_o, .chg_det_o, .chg_det_oe_o, .meas_bat_o, .meas_chg_o,
    .chg_pwm_o, .rst_level_o
  );

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ser_bits(input logic [15:0] frame, input int nbits);
    @(negedge clk);
    scs_ni = 1'b0;
    wait_cyc(4);
    for (int i = 15; i > 15 - nbits; i--) begin
      sdat_i = frame[i];
      sclk_i = 1'b0;
      wait_cyc(4);
      sclk_i = 1'b1;
      wait_cyc(4);
    end
    sclk_i = 1'b0;
    wait_cyc(4);
    scs_ni = 1'b1;
    wait_cyc(8);
  endtask

  task automatic ser_write(input logic [7:0] a, input logic [7:0] d);
    ser_bits({a, d}, 16);
  endtask

  task automatic wait_release(output int cyc);
    cyc = 0;
    while (!sys_rst_no && cyc < 3000) begin
      wait_cyc(1);
      cyc++;
    end
  endtask

  task automatic count_pwm(output int highs);
    highs = 0;
    for (int i = 0; i < 256; i++) begin
      wait_cyc(1);
      if (chg_pwm_o) highs++;
    end
  endtask

  initial begin
    wait_cyc(150000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: bench timed out");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int cyc, h;
    wait_cyc(5);
    // reset state
    chk("R2 off vsl", reg_vsl_en_o, 0);
    chk("R2 off reset", sys_rst_no, 0);
    chk("R8 off sleep line", sleep_line_o, 0);
    chk("R7 off pwm", chg_pwm_o, 0);
    chk("R12 default level", rst_level_o, 8'h33);
    rst_ni = 1'b1;
    wait_cyc(20);
    chk("R6 no edge stays off", reg_vsl_en_o, 0);

    // R2/R3 battery attach
    bat_attach_i = 1'b1;
    wait_cyc(6);
    chk("R2 bat wake vsl", reg_vsl_en_o, 1);
    chk("R2 bat wake reset low", sys_rst_no, 0);
    chk("R7 pwm forced in reset", chg_pwm_o, 1);
    chk("R8 sleep line high in reset", sleep_line_o, 1);
    chk("R9 det input in reset", chg_det_oe_o, 0);
    chk("R10 meas open in reset", {meas_bat_o, meas_chg_o}, 0);
    wait_release(cyc);
    chk("R3 delay window", (cyc + 6 >= PON_CYC - 5) && (cyc + 6 <= PON_CYC + 10), 1);
    chk("R8 handover at release", sleep_line_o, sleep_req_ni);
    chk("R9 det output at release", {chg_det_oe_o, chg_det_o}, 2'b10);
    chk("R7 pwm still forced", chg_pwm_o, 1);

    // R4 full first window counted from release
    wait_cyc(WD_DEF_CYC - 150);
    chk("R4 first window full", reg_vsl_en_o, 1);
    wait_cyc(300);
    chk("R4 default expiry", reg_vsl_en_o, 0);
    wait_cyc(50);
    chk("R6 held level no rewake", reg_vsl_en_o, 0);

    // charger wake, table walk
    chg_present_i = 1'b1;
    wait_release(cyc);
    chk("R9 det drives charger", {chg_det_oe_o, chg_det_o}, 2'b11);
    for (int k = 0; k < 8; k++) begin
      ser_write(8'h02, 8'h00);
      ser_write(8'h04, {6'd0, VEC[k][7:6]});
      ser_write(8'h05, {6'd0, VEC[k][5:4]});
      sleep_req_ni = VEC[k][8];
      wait_cyc(2);
      chk("R8 follows request", sleep_line_o, VEC[k][8]);
      chk("R11 regulators", {reg_vsl_en_o, reg_main_en_o, reg_aux_en_o}, {1'b1, VEC[k][3:2]});
      chk("R10 meas switches", {meas_bat_o, meas_chg_o}, VEC[k][1:0]);
    end
    // R1 unknown address and aborted frame
    ser_write(8'h7F, 8'hFF);
    chk("R1 unknown addr ignored", {meas_bat_o, meas_chg_o, reg_main_en_o, reg_aux_en_o}, 0);
    ser_bits({8'h05, 8'hFF}, 12);
    chk("R1 aborted frame ignored", {meas_bat_o, meas_chg_o}, 0);
    sleep_req_ni = 1'b1;
    ser_write(8'h02, 8'h00);

    // R7 PWM
    count_pwm(h);
    chk("R7 forced before first write", h, 256);
    ser_write(8'h06, 8'd64);
    count_pwm(h);
    chk("R7 duty 64", h, 64);
    ser_write(8'h06, 8'd0);
    count_pwm(h);
    chk("R7 duty 0", h, 0);

    // R12 level write
    ser_write(8'h03, 8'h2A);
    chk("R12 level written", rst_level_o, 8'h2A);

    // R5 shutdown by zero length
    ser_write(8'h01, 8'h00);
    chk("R5 zero length off", reg_vsl_en_o, 0);
    chk("R12 level kept off", rst_level_o, 8'h2A);
    wait_cyc(50);
    chk("R6 charger held no rewake", reg_vsl_en_o, 0);

    // R6 charger reinsert
    chg_present_i = 1'b0;
    wait_cyc(10);
    chg_present_i = 1'b1;
    wait_release(cyc);
    chk("R6 reinsert wakes", sys_rst_no, 1);
    chk("R7 forced again after wake", chg_pwm_o, 1);
    ser_write(8'h01, 8'h01);
    wait_cyc(60);
    chk("R4 short length alive", reg_vsl_en_o, 1);
    wait_cyc(100);
    chk("R4 short length expiry", reg_vsl_en_o, 0);

    // R2 button wake, R4 acknowledge
    pwr_btn_ni = 1'b0;
    wait_cyc(6);
    chk("R2 button wake", reg_vsl_en_o, 1);
    pwr_btn_ni = 1'b1;
    wait_release(cyc);
    ser_write(8'h01, 8'h02);
    for (int k = 0; k < 4; k++) ser_write(8'h02, 8'h00);
    chk("R4 acks keep alive", reg_vsl_en_o, 1);
    wait_cyc(200);
    chk("R4 alive inside window", reg_vsl_en_o, 1);
    wait_cyc(150);
    chk("R4 off without ack", reg_vsl_en_o, 0);

    // R6 length default after power off
    pwr_btn_ni = 1'b0;
    wait_cyc(6);
    pwr_btn_ni = 1'b1;
    wait_release(cyc);
    wait_cyc(600);
    chk("R6 length back to default", reg_vsl_en_o, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule